// File: doc/BRIEF.md
# Receive Frame Length Trimmer

This block sits in an Ethernet receive path after the preamble and start-of-frame delimiter have been removed. It takes a byte stream with start and end markers and passes it on toward the receive FIFO. The first byte it forwards is the first destination-address byte. Forwarding runs one cycle behind the input. While a frame streams through, the block decides how many bytes to pass.

When stripping is enabled and the 16-bit length/type field holds a length (below 0x600), only the header plus that many data bytes go out. Pad and FCS are discarded. A type value (0x600 and above) always passes the whole frame. A size guard stops oversized frames. With the guard enabled it stops them at 2048 bytes. With the guard disabled it still stops them at 16384 bytes. When a frame is cut off, the last forwarded byte carries the end marker and the rest of the frame is dropped.

After each frame ends at the input, a one-cycle status word reports three things: the forwarded byte count, a timeout flag and a flag saying whether length stripping was in force.

Top module: `rx_len_trim`

## Requirements
- R1: Each forwarded byte appears on the outputs one clock after it is accepted, with its data unchanged. The first byte after a start marker (the first destination-address byte) carries `out_sof`.
- R2: The length/type field is frame bytes 12 (upper) and 13 (lower). If `strip_en` was high at the start byte and the field is below 0x600, at most 14 + field bytes are forwarded. The remaining bytes are dropped.
- R3: If the field is 0x600 or above, every byte of the frame is forwarded, whatever the value of `strip_en`.
- R4: With `strip_en` low at the start byte, a frame whose field is below 0x600 is forwarded whole.
- R5: With `wdog_dis` low at the start byte, at most 2048 bytes are forwarded. A frame longer than 2048 bytes reports a timeout.
- R6: With `wdog_dis` high at the start byte, frames of up to 16384 bytes pass whole and report no timeout. Longer frames are cut at 16384 bytes and report a timeout.
- R7: A frame that is shortened carries `out_eof` on its last forwarded byte. No further byte of that frame is forwarded.
- R8: `stat_valid` pulses for one cycle, one clock after the input byte that carries the end marker. It reports `stat_count` (bytes forwarded), `stat_timeout` and `stat_stripped`. `stat_stripped` is high when byte 13 was seen with stripping enabled and a field below 0x600.
- R9: Bytes that arrive between frames (valid without a start marker after an end marker) produce no output and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte after the delimiter |
| in_eof | input | 1 | Last byte of the frame |
| strip_en | input | 1 | Enable pad/FCS stripping for length frames, sampled at the start byte |
| wdog_dis | input | 1 | Raise the size guard from 2048 to 16384 bytes, sampled at the start byte |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First forwarded byte of a frame |
| out_eof | output | 1 | Last forwarded byte of a frame |
| stat_valid | output | 1 | Status word valid |
| stat_count | output | CNT_W (15) | Bytes forwarded for the frame |
| stat_timeout | output | 1 | Frame exceeded the active size guard |
| stat_stripped | output | 1 | Length-based stripping was in force |

## Verification
Each forwarded byte is due on the outputs one clock after the edge that accepts it. The status word is due one clock after the edge that accepts the end-marked input byte. The bench drives inputs and samples outputs at the falling edge. Each byte check therefore reads the result of the preceding rising edge. A monitor compares every output byte, in order, with a queue built by a bench model of R2 to R6. The sender reads the status at the first falling edge after the end byte and checks that the queue is empty one cycle later. It also checks the first-byte latency directly on the second input byte.

// File: rtl/rx_len_trim.sv
module rx_len_trim #(
  parameter int          WD_LIMIT   = 2048,
  parameter int          HARD_LIMIT = 16384,
  parameter logic [15:0] TYPE_BOUND = 16'h0600,
  parameter int          HDR_BYTES  = 14,
  localparam int         CNT_W      = $clog2(HARD_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             strip_en,
  input  logic             wdog_dis,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             stat_valid,
  output logic [CNT_W-1:0] stat_count,
  output logic             stat_timeout,
  output logic             stat_stripped
);

  logic             active, strip_r, hit_r, to_r;
  logic [CNT_W-1:0] idx, lim, cap, cnt;
  logic [7:0]       lt_hi;

  logic             take, trim, fwd, over, last;
  logic             strip_use, hit_cur, to_cur;
  logic [CNT_W-1:0] cur_idx, cap_use, lim_base, lim_use, cnt_cur;
  logic [15:0]      lt;
  logic [16:0]      len_lim;

  assign take      = in_valid && (in_sof || active);
  assign cur_idx   = in_sof ? '0 : idx;
  assign cap_use   = in_sof ? (wdog_dis ? CNT_W'(HARD_LIMIT) : CNT_W'(WD_LIMIT)) : cap;
  assign strip_use = in_sof ? strip_en : strip_r;
  assign hit_cur   = in_sof ? 1'b0 : hit_r;
  assign to_cur    = in_sof ? 1'b0 : to_r;
  assign cnt_cur   = in_sof ? '0 : cnt;
  assign lim_base  = in_sof ? cap_use : lim;

  assign lt      = {lt_hi, in_data};
  assign len_lim = 17'(HDR_BYTES) + {1'b0, lt};
  assign trim    = take && strip_use && (cur_idx == CNT_W'(HDR_BYTES - 1)) && (lt < TYPE_BOUND);
  assign lim_use = (trim && (len_lim < 17'(lim_base))) ? CNT_W'(len_lim) : lim_base;

  assign fwd  = take && (cur_idx < lim_use);
  assign over = take && (cur_idx >= cap_use);
  assign last = fwd && (in_eof || (cur_idx + 1'b1 == lim_use));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      lim     <= '0;
      cap     <= '0;
      cnt     <= '0;
      strip_r <= 1'b0;
      hit_r   <= 1'b0;
      to_r    <= 1'b0;
      lt_hi   <= '0;
    end else if (take) begin
      active  <= !in_eof;
      idx     <= (cur_idx < cap_use) ? cur_idx + 1'b1 : cur_idx;
      lim     <= lim_use;
      cap     <= cap_use;
      cnt     <= cnt_cur + CNT_W'(fwd);
      strip_r <= strip_use;
      hit_r   <= hit_cur | trim;
      to_r    <= to_cur | over;
      if (cur_idx == CNT_W'(HDR_BYTES - 2)) lt_hi <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_sof       <= 1'b0;
      out_eof       <= 1'b0;
      stat_valid    <= 1'b0;
      stat_count    <= '0;
      stat_timeout  <= 1'b0;
      stat_stripped <= 1'b0;
    end else begin
      out_valid  <= fwd;
      out_data   <= in_data;
      out_sof    <= fwd && (cur_idx == '0);
      out_eof    <= last;
      stat_valid <= take && in_eof;
      if (take && in_eof) begin
        stat_count    <= cnt_cur + CNT_W'(fwd);
        stat_timeout  <= to_cur | over;
        stat_stripped <= hit_cur | trim;
      end
    end
  end

endmodule

// File: rtl/rx_len_trim_chk.sv
module rx_len_trim_chk #(
  parameter int HARD_LIMIT = 16384,
  parameter int CNT_W      = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [7:0]       in_data,
  input logic             in_sof,
  input logic             in_eof,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic             stat_valid,
  input logic [CNT_W-1:0] stat_count
);

  assert_data_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data == $past(in_data) && $past(in_valid)));

  assert_sof_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_valid && $past(in_sof)));

  assert_eof_with_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);

  assert_status_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(in_valid && in_eof));

  assert_status_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid || $past(in_valid && in_eof));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (int'(stat_count) <= HARD_LIMIT));

endmodule

bind rx_len_trim rx_len_trim_chk #(.HARD_LIMIT(HARD_LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_sof(in_sof), .in_eof(in_eof), .out_valid(out_valid), .out_data(out_data),
  .out_sof(out_sof), .out_eof(out_eof), .stat_valid(stat_valid), .stat_count(stat_count)
);

// File: tb/rx_len_trim_bench.sv
module rx_len_trim_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, strip_en = 1'b0, wdog_dis = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, out_sof, out_eof, stat_valid, stat_timeout, stat_stripped;
  logic [7:0] out_data;
  logic [14:0] stat_count;

  always #5 clk = ~clk;

  rx_len_trim u_rx_len_trim (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .strip_en(strip_en), .wdog_dis(wdog_dis),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .stat_valid(stat_valid), .stat_count(stat_count), .stat_timeout(stat_timeout),
    .stat_stripped(stat_stripped)
  );

  int checks = 0, errors = 0, stray = 0;
  string tag = "R1";
  logic [9:0] exq[$];
  logic [9:0] mon_e;
  logic [7:0] frm [0:16399];

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exq.size() == 0) begin
        errors++; stray++;
        $display("FAIL %s unexpected byte: got %h, expected none", tag, out_data);
      end else begin
        mon_e = exq.pop_front();
        if ({out_sof, out_eof, out_data} !== mon_e) begin
          errors++;
          $display("FAIL %s byte: got sof=%b eof=%b %h, expected sof=%b eof=%b %h",
                   tag, out_sof, out_eof, out_data, mon_e[9], mon_e[8], mon_e[7:0]);
        end
      end
    end
  end

  function automatic int exp_cap(bit wdis);
    return wdis ? 16384 : 2048;
  endfunction

  function automatic bit exp_strip(int n, logic [15:0] lt, bit strip);
    return (n >= 14) && strip && (lt < 16'h0600);
  endfunction

  function automatic int exp_count(int n, logic [15:0] lt, bit strip, bit wdis);
    int lim;
    lim = exp_cap(wdis);
    if (exp_strip(n, lt, strip) && (14 + int'(lt) < lim)) lim = 14 + int'(lt);
    return (n < lim) ? n : lim;
  endfunction

  task automatic send(int n, logic [15:0] lt, bit strip, bit wdis);
    int fc;
    bit to, st;
    fc = exp_count(n, lt, strip, wdis);
    to = n > exp_cap(wdis);
    st = exp_strip(n, lt, strip);
    if (to) tag = wdis ? "R6" : "R5";
    else if (st) tag = "R2";
    else if (lt >= 16'h0600) tag = "R3";
    else tag = "R4";
    for (int i = 0; i < n; i++)
      frm[i] = (i == 12) ? lt[15:8] : (i == 13) ? lt[7:0] : 8'($urandom);
    for (int i = 0; i < fc; i++) exq.push_back({i == 0, i == fc - 1, frm[i]});
    for (int i = 0; i < n; i++) begin
      if (i > 1 && ($urandom % 4) == 0) begin
        @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk);
      if (i == 1) begin
        checks++;
        if (!(out_valid && out_sof && out_data == frm[0])) begin
          errors++;
          $display("FAIL R1 first byte latency: got v=%b sof=%b %h, expected v=1 sof=1 %h",
                   out_valid, out_sof, out_data, frm[0]);
        end
      end
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1);
      in_data = frm[i]; strip_en = strip; wdog_dis = wdis;
    end
    @(negedge clk);
    checks++;
    if (!(stat_valid && int'(stat_count) == fc && stat_timeout == to && stat_stripped == st)) begin
      errors++;
      $display("FAIL R8/%s status: got v=%b cnt=%0d to=%b st=%b, expected v=1 cnt=%0d to=%b st=%b",
               tag, stat_valid, stat_count, stat_timeout, stat_stripped, fc, to, st);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    @(negedge clk);
    #1;
    checks++;
    if (exq.size() != 0 || stat_valid) begin
      errors++;
      $display("FAIL R7 %s leftover: got %0d missing bytes stat=%b, expected 0 stat=0",
               tag, exq.size(), stat_valid);
      exq.delete();
    end
  endtask

  task automatic junk(int k);
    int s0;
    bit sv;
    s0 = stray; sv = 1'b0;
    tag = "R9";
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      sv |= stat_valid;
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == k - 1); in_data = 8'($urandom);
    end
    @(negedge clk); sv |= stat_valid; in_valid = 1'b0; in_eof = 1'b0;
    @(negedge clk); sv |= stat_valid;
    #1;
    checks++;
    if (stray != s0 || sv) begin
      errors++;
      $display("FAIL R9 idle bytes: got %0d outputs stat=%b, expected 0 stat=0", stray - s0, sv);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid || stat_valid || out_sof || out_eof) begin
      errors++;
      $display("FAIL R1 reset: got v=%b stat=%b, expected 0 0", out_valid, stat_valid);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send(60, 16'd20, 1'b1, 1'b0);
    send(60, 16'd0, 1'b1, 1'b0);
    send(60, 16'd46, 1'b1, 1'b0);
    send(60, 16'd200, 1'b1, 1'b0);
    send(13, 16'd0, 1'b1, 1'b0);
    send(80, 16'h05FF, 1'b1, 1'b0);
    send(80, 16'h0600, 1'b1, 1'b0);
    send(80, 16'h0800, 1'b0, 1'b0);
    send(80, 16'd10, 1'b0, 1'b0);
    send(1, 16'd0, 1'b1, 1'b0);
    junk(5);
    send(2048, 16'h0800, 1'b0, 1'b0);
    send(2049, 16'h0800, 1'b0, 1'b0);
    send(2100, 16'd30, 1'b0, 1'b0);
    send(3000, 16'h0800, 1'b1, 1'b1);
    send(16384, 16'h0800, 1'b0, 1'b1);
    send(16390, 16'h86DD, 1'b1, 1'b1);

    for (int f = 0; f < 40; f++) begin
      int n, k;
      logic [15:0] lt;
      n = 1 + int'($urandom % 120);
      k = int'($urandom % 4);
      case (k)
        0: lt = 16'($urandom % n);
        1: lt = 16'h0600 + 16'($urandom % 100);
        2: lt = 16'h05FF;
        default: lt = 16'($urandom % 16);
      endcase
      send(n, lt, 1'($urandom), 1'($urandom));
      if (f % 10 == 0) junk(3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end of test, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule